// File: doc/BRIEF.md
# Loop frequency profiling cache

This block keeps a running tally of how often each loop-closing branch is taken. A neighbouring observer presents the address of every short backward branch it sees, together with a weight (one for a single taken branch, or a larger amount when several consecutive takes are merged or sampled). The table stores a tag and a count for each tracked branch in a small two-way set-associative array. Over time, the entries with the largest counts point to the hottest loops of the running program.

A request that matches a stored tag adds its weight to that count. A request that matches nothing claims a way in its set, preferring an empty way and otherwise evicting the way used longest ago. If adding a weight would push a count past its maximum, the block first walks through the whole table one set per cycle and halves every count. This keeps the ratios between loops while making room. The stalled request is then applied to the halved value. A separate read port lets a host walk the table and rank the entries.

Top module: `loopprof_cache`

## Requirements
- R1: After reset every entry reads back invalid with tag and count zero, `busy_o` is low and `req_ready_o` is high while no overflowing request is offered.
- R2: The set index is `req_addr_i[5:2]` and the tag is `req_addr_i[31:6]` (default sizes). Bits [1:0] have no effect on lookup.
- R3: An accepted request whose tag matches a valid way of its set adds `req_inc_i` to that way's count, provided the sum fits in the count width.
- R4: An accepted request that misses fills the lowest-numbered invalid way of its set, or way 0 before way 1. The filled way becomes valid, holds the tag and holds `req_inc_i` as its count.
- R5: Each set has one LRU bit. A hit or a fill makes that way most recently used. A miss in a set with both ways valid replaces the least recently used way.
- R6: A request that hits and whose sum would exceed the count maximum is not accepted in that cycle. `busy_o` then stays high for exactly 16 cycles (one per set). During that time each count in the table is replaced by its value shifted right one bit, and valid bits, tags and LRU bits are left unchanged.
- R7: When the halving pass ends, the still-offered request is accepted and adds its increment to the halved count.
- R8: The read port returns the valid bit, tag and count of the entry selected by `rd_set_i`/`rd_way_i` one cycle later. The value returned is the one the entry held before that clock edge.
- R9: `req_ready_o` is low in every cycle where `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Update request present |
| req_ready_o | output | 1 | Update request accepted this cycle when high with valid |
| req_addr_i | input | 32 | Branch address |
| req_inc_i | input | 8 | Amount added to the count |
| busy_o | output | 1 | Halving pass in progress |
| rd_set_i | input | 4 | Set to read |
| rd_way_i | input | 1 | Way to read |
| rd_valid_o | output | 1 | Valid bit of the read entry |
| rd_tag_o | output | 26 | Tag of the read entry |
| rd_cnt_o | output | 24 | Count of the read entry |

## Verification
The bench instantiates the block with a 12-bit count field and leaves the address width, set count and increment width at their defaults. With the narrower count, a handful of maximum-weight requests brings an entry to overflow. Many halving passes therefore occur, both in a directed sequence and during a long random run. Weights and delays are random in that run, and the tags come from a small pool so that hits, evictions and stalls mix freely.

// File: rtl/loopprof_pkg.sv
package loopprof_pkg;
  localparam int unsigned LP_WAYS = 2;

  // lowest invalid way first, else the least recently used one
  function automatic logic lp_victim(input logic [LP_WAYS-1:0] vld, input logic lru);
    if (!vld[0]) return 1'b0;
    if (!vld[1]) return 1'b1;
    return lru;
  endfunction
endpackage

// File: rtl/loopprof_lookup.sv
module loopprof_lookup
  import loopprof_pkg::*;
#(
  parameter int unsigned TAG_W = 26,
  parameter int unsigned CNT_W = 24,
  parameter int unsigned INC_W = 8
) (
  input  logic [LP_WAYS-1:0]            vld_i,
  input  logic [LP_WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [LP_WAYS-1:0][CNT_W-1:0] cnt_i,
  input  logic                          lru_i,
  input  logic [TAG_W-1:0]              req_tag_i,
  input  logic [INC_W-1:0]              req_inc_i,
  output logic                          hit_o,
  output logic                          hit_way_o,
  output logic                          ovf_o,
  output logic [CNT_W-1:0]              sum_o,
  output logic                          alloc_way_o
);
  logic [LP_WAYS-1:0] match;
  logic [CNT_W:0]     ext_sum;

  for (genvar w = 0; w < LP_WAYS; w++) begin : g_cmp
    assign match[w] = vld_i[w] && (tag_i[w] == req_tag_i);
  end

  assign hit_o       = |match;
  assign hit_way_o   = match[1];
  assign ext_sum     = {1'b0, cnt_i[hit_way_o]} + {{(CNT_W+1-INC_W){1'b0}}, req_inc_i};
  assign ovf_o       = ext_sum[CNT_W];
  assign sum_o       = ext_sum[CNT_W-1:0];
  assign alloc_way_o = lp_victim(vld_i, lru_i);
endmodule

// File: rtl/loopprof_sweep.sv
module loopprof_sweep #(
  parameter int unsigned SETS  = 16,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (busy_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == IDX_W'(SETS-1)) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/loopprof_cache.sv
module loopprof_cache
  import loopprof_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SETS   = 16,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned INC_W  = 8,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned TAG_W = ADDR_W - IDX_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [INC_W-1:0]  req_inc_i,
  output logic              busy_o,
  input  logic [IDX_W-1:0]  rd_set_i,
  input  logic              rd_way_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [CNT_W-1:0]  rd_cnt_o
);
  logic [LP_WAYS-1:0]            vld_q [SETS];
  logic [LP_WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [LP_WAYS-1:0][CNT_W-1:0] cnt_q [SETS];
  logic [SETS-1:0]               lru_q;

  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic             unused_lsb;
  logic             hit, hit_way, ovf, alloc_way;
  logic [CNT_W-1:0] sum;
  logic             upd_en, sweep_en, sweep_start;
  logic [IDX_W-1:0] sweep_idx;

  assign req_idx    = req_addr_i[IDX_W+1:2];
  assign req_tag    = req_addr_i[ADDR_W-1:IDX_W+2];
  assign unused_lsb = ^req_addr_i[1:0];

  loopprof_lookup #(.TAG_W(TAG_W), .CNT_W(CNT_W), .INC_W(INC_W)) lookup_i (
    .vld_i       (vld_q[req_idx]),
    .tag_i       (tag_q[req_idx]),
    .cnt_i       (cnt_q[req_idx]),
    .lru_i       (lru_q[req_idx]),
    .req_tag_i   (req_tag),
    .req_inc_i   (req_inc_i),
    .hit_o       (hit),
    .hit_way_o   (hit_way),
    .ovf_o       (ovf),
    .sum_o       (sum),
    .alloc_way_o (alloc_way)
  );

  loopprof_sweep #(.SETS(SETS)) sweep_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sweep_start),
    .busy_o  (sweep_en),
    .idx_o   (sweep_idx)
  );

  // an overflowing hit stalls; it is retried against the halved table
  assign sweep_start = req_valid_i && !sweep_en && hit && ovf;
  assign req_ready_o = !sweep_en && !(req_valid_i && hit && ovf);
  assign upd_en      = req_valid_i && req_ready_o;
  assign busy_o      = sweep_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        tag_q[s] <= '0;
        cnt_q[s] <= '0;
      end
      lru_q      <= '0;
      rd_valid_o <= 1'b0;
      rd_tag_o   <= '0;
      rd_cnt_o   <= '0;
    end else begin
      rd_valid_o <= vld_q[rd_set_i][rd_way_i];
      rd_tag_o   <= tag_q[rd_set_i][rd_way_i];
      rd_cnt_o   <= cnt_q[rd_set_i][rd_way_i];
      if (sweep_en) begin
        for (int w = 0; w < LP_WAYS; w++)
          cnt_q[sweep_idx][w] <= cnt_q[sweep_idx][w] >> 1;
      end else if (upd_en) begin
        if (hit) begin
          cnt_q[req_idx][hit_way] <= sum;
          lru_q[req_idx]          <= ~hit_way;
        end else begin
          vld_q[req_idx][alloc_way] <= 1'b1;
          tag_q[req_idx][alloc_way] <= req_tag;
          cnt_q[req_idx][alloc_way] <= {{(CNT_W-INC_W){1'b0}}, req_inc_i};
          lru_q[req_idx]            <= ~alloc_way;
        end
      end
    end
  end
endmodule

// File: rtl/loopprof_chk.sv
module loopprof_chk #(
  parameter int unsigned SETS = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic busy_o,
  input logic upd_en_i,
  input logic sweep_en_i
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 0;
    else         run_q <= busy_o ? run_q + 1 : 0;
  end

  assert_busy_blocks_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o);

  assert_sweep_length_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == SETS));

  assert_sweep_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i && !req_ready_o));

  assert_no_write_clash_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_en_i && sweep_en_i));
endmodule

bind loopprof_cache loopprof_chk #(.SETS(SETS)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .busy_o      (busy_o),
  .upd_en_i    (upd_en),
  .sweep_en_i  (sweep_en)
);

// File: tb/loopprof_cache_tb_top.sv
module loopprof_cache_tb_top;
  localparam int ADDR_W = 32;
  localparam int SETS   = 16;
  localparam int CNT_W  = 12;
  localparam int INC_W  = 8;
  localparam int TAG_W  = ADDR_W - 4 - 2;
  localparam longint CMAX = (64'd1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [INC_W-1:0]  req_inc = '0;
  logic              busy;
  logic [3:0]        rd_set = '0;
  logic              rd_way = 1'b0;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [CNT_W-1:0]  rd_cnt;

  always #10 clk = ~clk;

  loopprof_cache #(.ADDR_W(ADDR_W), .SETS(SETS), .CNT_W(CNT_W), .INC_W(INC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_inc_i(req_inc), .busy_o(busy),
    .rd_set_i(rd_set), .rd_way_i(rd_way), .rd_valid_o(rd_valid),
    .rd_tag_o(rd_tag), .rd_cnt_o(rd_cnt)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, longint got, longint exp, string what);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // behavioural reference model
  bit          m_v   [SETS][2];
  longint      m_tag [SETS][2];
  longint      m_cnt [SETS][2];
  bit          m_lru [SETS];
  bit          m_busy;
  int          m_idx;
  bit          e_rv;
  longint      e_rt, e_rc;

  task automatic m_init();
    foreach (m_v[s, w]) begin m_v[s][w] = 0; m_tag[s][w] = 0; m_cnt[s][w] = 0; end
    foreach (m_lru[s]) m_lru[s] = 0;
    m_busy = 0; m_idx = 0; e_rv = 0; e_rt = 0; e_rc = 0;
  endtask

  function automatic int m_find(int s, longint t);
    for (int w = 0; w < 2; w++) if (m_v[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic bit m_stall();
    int s = int'(req_addr[5:2]);
    int w = m_find(s, longint'(req_addr[ADDR_W-1:6]));
    return req_valid && w >= 0 && (m_cnt[s][w] + longint'(req_inc) > CMAX);
  endfunction

  initial m_init();

  always @(posedge clk) begin
    if (!rst_n) m_init();
    else begin
      int s, w;
      longint t;
      e_rv = m_v[rd_set][rd_way]; e_rt = m_tag[rd_set][rd_way]; e_rc = m_cnt[rd_set][rd_way];
      if (m_busy) begin
        for (int k = 0; k < 2; k++) m_cnt[m_idx][k] = m_cnt[m_idx][k] / 2;
        if (m_idx == SETS-1) m_busy = 0;
        m_idx++;
      end else if (req_valid) begin
        s = int'(req_addr[5:2]);
        t = longint'(req_addr[ADDR_W-1:6]);
        w = m_find(s, t);
        if (m_stall()) begin
          m_busy = 1; m_idx = 0;
        end else if (w >= 0) begin
          m_cnt[s][w] += longint'(req_inc); m_lru[s] = (w == 0);
        end else begin
          w = !m_v[s][0] ? 0 : (!m_v[s][1] ? 1 : int'(m_lru[s]));
          m_v[s][w] = 1; m_tag[s][w] = t; m_cnt[s][w] = longint'(req_inc);
          m_lru[s] = (w == 0);
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9", longint'(req_ready), longint'(!m_busy && !m_stall()), "ready");
      chk("R6", longint'(busy), longint'(m_busy), "busy");
      chk("R8", longint'(rd_valid), longint'(e_rv), "rd_valid");
      chk("R8", longint'(rd_tag), e_rt, "rd_tag");
      chk("R8", longint'(rd_cnt), e_rc, "rd_cnt");
    end
  end

  function automatic logic [ADDR_W-1:0] mk(int set, int tag);
    return (ADDR_W'(tag) << 6) | (ADDR_W'(set) << 2);
  endfunction

  int busy_seen;
  bit rnd_rd = 0;

  task automatic do_req(logic [ADDR_W-1:0] a, int inc);
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_inc = INC_W'(inc);
    if (rnd_rd) begin rd_set = 4'($urandom); rd_way = 1'($urandom); end
    forever begin
      @(negedge clk);
      if (req_ready) break;
      if (busy) busy_seen++;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic peek(int set, int way);
    @(posedge clk); #1;
    rd_set = 4'(set); rd_way = 1'(way);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    peek(5, 1);
    chk("R1", longint'(rd_valid), 0, "valid after reset");
    chk("R1", longint'(rd_cnt), 0, "count after reset");
    chk("R1", longint'(req_ready), 1, "ready after reset");
    chk("R1", longint'(busy), 0, "busy after reset");

    do_req(mk(3, 1), 5);
    peek(3, 0);
    chk("R4", longint'(rd_valid), 1, "fill way0 valid");
    chk("R4", longint'(rd_tag), 1, "fill way0 tag");
    chk("R4", longint'(rd_cnt), 5, "fill way0 count");
    do_req(mk(3, 2), 7);
    peek(3, 1);
    chk("R4", longint'(rd_tag), 2, "fill way1 tag");
    chk("R4", longint'(rd_cnt), 7, "fill way1 count");
    do_req(mk(3, 1), 10);
    peek(3, 0);
    chk("R3", longint'(rd_cnt), 15, "hit adds");
    do_req(mk(3, 3), 1);
    peek(3, 1);
    chk("R5", longint'(rd_tag), 3, "lru way replaced");
    peek(3, 0);
    chk("R5", longint'(rd_tag), 1, "mru way kept");
    do_req(mk(3, 1) | 32'h3, 1);
    peek(3, 0);
    chk("R2", longint'(rd_cnt), 16, "low bits ignored");
    do_req(mk(3, 4), 9);
    peek(3, 1);
    chk("R5", longint'(rd_tag), 4, "second eviction");
    do_req(mk(0, 7), 100);

    for (int i = 0; i < 15; i++) do_req(mk(3, 1), 255);
    peek(3, 0);
    chk("R3", longint'(rd_cnt), 3841, "count before overflow");
    busy_seen = 0;
    do_req(mk(3, 1), 255);
    chk("R6", longint'(busy_seen), 16, "halving pass length");
    peek(3, 0);
    chk("R7", longint'(rd_cnt), 2175, "stalled request on halved count");
    peek(3, 1);
    chk("R6", longint'(rd_cnt), 4, "other way halved");
    chk("R6", longint'(rd_tag), 4, "tag kept");
    peek(0, 0);
    chk("R6", longint'(rd_cnt), 50, "other set halved");
    chk("R6", longint'(rd_valid), 1, "valid kept");

    rnd_rd = 1;
    for (int i = 0; i < 2500; i++) begin
      do_req(mk(int'($urandom % 16), int'($urandom % 5)), int'($urandom % 256));
      if ($urandom % 4 == 0) repeat (int'($urandom % 3)) @(posedge clk);
    end
    for (int s = 0; s < SETS; s++) for (int w = 0; w < 2; w++) peek(s, w);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule